// File: doc/BRIEF.md
# Seven-Bit Serial Lane Frame Receiver

This block turns several serial lanes back into one parallel word. Each lane carries seven bits per frame. A framing lane runs beside them and sets the frame boundaries. The block runs on a clock at the bit rate and samples every lane once per cycle. A low-to-high change on the framing lane marks the first bit-time of a frame. The bits each data lane delivers in that frame are gathered into a group of seven word bits. One parameter picks four data lanes, which give a 28-bit word, or three lanes, which give a 21-bit word.

A finished word is held in a two-deep stage. It reaches the output exactly two frame periods after its first bit was sampled. A regenerated strobe, high for a little over half of each frame, rises mid-frame, so a downstream register can capture the word on that rising edge.

The block also qualifies lock before it delivers any word. It drops lock and holds the last word when the framing lane stops toggling. It drives the word to all zeros during power-down.

Top module: `septet_lane_rx`

## Requirements
- R1: While reset is held, `word_out` is zero and `strobe_out` and `locked` are low.
- R2: Serial position 0 of a frame is the bit-time whose framing-lane sample is the first high after a low. Positions 1 to 6 follow in time order. Data lane k at position j goes to word bit 7k+j.
- R3: A frame whose position 0 is sampled at clock edge n appears on `word_out` just after edge n+14 and not earlier. Outside power-down, `word_out` changes only at a frame-start edge while `locked` is high.
- R4: While locked, `strobe_out` is low after the edges that sample positions 0 to 2 and high after the edges that sample positions 3 to 6.
- R5: A well-formed frame is seven bit-times long, with the framing lane high at positions 0 to 3 and low at positions 4 to 6. `locked` rises after position 6 of the second of two consecutive well-formed frames. A malformed frame restarts the count. The first word delivered is the first frame of that pair.
- R6: When `pd_n` is sampled low at an edge, `word_out` is zero and `strobe_out` and `locked` are low after that edge, and they stay so for as long as `pd_n` stays low.
- R7: With the framing lane toggling normally and every data lane held high, each delivered word is all ones.
- R8: After 14 consecutive bit-times with no change on the framing lane, `locked` and `strobe_out` are low after the 14th, and `word_out` keeps its last value. Lock is regained only as described in R5.
- R9: With three data lanes, the word is 21 bits wide and follows the same mapping, latency and lock rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Active-low power-down |
| fc_in | input | 1 | Framing-lane sample (four high, three low per frame) |
| din | input | LANES | One sample per data lane |
| word_out | output | LANES*7 | Recovered parallel word |
| strobe_out | output | 1 | Output strobe; the word is valid at its rising edge |
| locked | output | 1 | High while frame alignment is qualified |

## Verification
A wrong bit-position counter shows up at the ports as a rotated or mixed-up word, but only two frames later. A wrong word stage shows up as the right word at the wrong edge. For that reason the scoreboard checks each word on its exact due edge and also checks that it has not appeared one edge earlier. A wrong lock count or a wrong silence counter shows up through `locked` and `strobe_out` within one bit-time of the edge where the state should have changed, so a cycle history of those two outputs is compared against the expected edge. A power-down that fails to override the word stage shows up as a nonzero word after the first frame start during power-down.

// File: rtl/septet_rx_pkg.sv
package septet_rx_pkg;

  // level the framing lane should show at a given serial position
  function automatic logic clk_level_expected(input int pos, input int high_bits);
    return pos < high_bits;
  endfunction

  // word index fed by a lane at a serial position
  function automatic int bit_slot(input int lane, input int pos, input int slot_bits);
    return lane * slot_bits + pos;
  endfunction

  // strobe is high over the later part of the frame
  function automatic logic in_strobe_window(input int pos, input int slot_bits);
    return (pos >= slot_bits / 2) && (pos < slot_bits);
  endfunction

endpackage

// File: rtl/septet_frame_track.sv
module septet_frame_track #(
  parameter int SLOT_BITS  = 7,
  parameter int CLK_HIGH   = 4,
  parameter int LOSS_LIMIT = 14,
  parameter int POS_W      = $clog2(SLOT_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_in,
  output logic             start,
  output logic [POS_W-1:0] pos_now,
  output logic             frame_good,
  output logic             frame_bad,
  output logic             loss
);
  import septet_rx_pkg::*;

  localparam int QW = $clog2(LOSS_LIMIT + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] POS_OVER = POS_W'(SLOT_BITS);
  localparam logic [QW-1:0]    Q_MAX    = QW'(LOSS_LIMIT);
  localparam logic [QW-1:0]    Q_TRIP   = QW'(LOSS_LIMIT - 1);

  logic             fc_q, ok_q, ok_now, change;
  logic [POS_W-1:0] pos_q;
  logic [QW-1:0]    quiet_q;

  always_comb begin
    change = fc_in ^ fc_q;
    start  = fc_in & ~fc_q;
    if (start)                 pos_now = '0;
    else if (pos_q == POS_OVER) pos_now = POS_OVER;
    else                       pos_now = pos_q + POS_W'(1);
    ok_now = (start | ok_q) & (pos_now != POS_OVER)
           & (fc_in == clk_level_expected(int'(pos_now), CLK_HIGH));
    frame_good = (pos_now == POS_LAST) & ok_now;
    frame_bad  = start ? ~((pos_q == POS_LAST) & ok_q) : (pos_q == POS_LAST);
    loss       = ~change & (quiet_q == Q_TRIP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fc_q    <= 1'b0;
      pos_q   <= POS_OVER;
      ok_q    <= 1'b0;
      quiet_q <= '0;
    end else begin
      fc_q  <= fc_in;
      pos_q <= pos_now;
      ok_q  <= ok_now;
      if (change)                quiet_q <= '0;
      else if (quiet_q != Q_MAX) quiet_q <= quiet_q + QW'(1);
    end
  end

  // R8
  loss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> !loss);

  // R5
  good_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> !frame_bad);

endmodule

// File: rtl/septet_lane_collect.sv
module septet_lane_collect #(
  parameter int LANES     = 4,
  parameter int SLOT_BITS = 7,
  parameter int POS_W     = $clog2(SLOT_BITS + 1),
  parameter int WORD_W    = LANES * SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  din,
  input  logic [POS_W-1:0]  pos_now,
  output logic [WORD_W-1:0] word_now
);
  import septet_rx_pkg::*;

  logic [WORD_W-1:0] gather_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gather_q <= '0;
    end else if (int'(pos_now) < SLOT_BITS) begin
      for (int ln = 0; ln < LANES; ln++)
        gather_q[bit_slot(ln, int'(pos_now), SLOT_BITS)] <= din[ln];
    end
  end

  // last position is taken straight from the lanes so the word is whole
  always_comb begin
    word_now = gather_q;
    for (int ln = 0; ln < LANES; ln++)
      word_now[bit_slot(ln, SLOT_BITS - 1, SLOT_BITS)] = din[ln];
  end

endmodule

// File: rtl/septet_lock_qual.sv
module septet_lock_qual #(
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic frame_good,
  input  logic frame_bad,
  input  logic loss,
  output logic locked
);
  localparam int CW = $clog2(LOCK_FRAMES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(LOCK_FRAMES);
  localparam logic [CW-1:0] CNT_ARM  = CW'(LOCK_FRAMES - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else begin
      if (!pd_n || loss || frame_bad)           run_q <= '0;
      else if (frame_good && run_q != CNT_FULL) run_q <= run_q + CW'(1);
      if (!pd_n || loss)                        locked <= 1'b0;
      else if (frame_good && run_q == CNT_ARM)  locked <= 1'b1;
    end
  end

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_good));

endmodule

// File: rtl/septet_lane_rx.sv
module septet_lane_rx #(
  parameter int LANES       = 4,
  parameter int SLOT_BITS   = 7,
  parameter int CLK_HIGH    = 4,
  parameter int LOSS_LIMIT  = 14,
  parameter int LOCK_FRAMES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pd_n,
  input  logic                       fc_in,
  input  logic [LANES-1:0]           din,
  output logic [LANES*SLOT_BITS-1:0] word_out,
  output logic                       strobe_out,
  output logic                       locked
);
  import septet_rx_pkg::*;

  localparam int WORD_W = LANES * SLOT_BITS;
  localparam int POS_W  = $clog2(SLOT_BITS + 1);

  logic             start, frame_good, frame_bad, loss, flush;
  logic [POS_W-1:0] pos_now;
  logic [WORD_W-1:0] word_now, stage_a, stage_b;
  logic             va, vb;

  septet_frame_track #(
    .SLOT_BITS(SLOT_BITS), .CLK_HIGH(CLK_HIGH),
    .LOSS_LIMIT(LOSS_LIMIT), .POS_W(POS_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .fc_in(fc_in), .start(start),
    .pos_now(pos_now), .frame_good(frame_good),
    .frame_bad(frame_bad), .loss(loss)
  );

  septet_lane_collect #(
    .LANES(LANES), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W), .WORD_W(WORD_W)
  ) u_collect (
    .clk(clk), .rst_n(rst_n), .din(din), .pos_now(pos_now),
    .word_now(word_now)
  );

  septet_lock_qual #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .frame_good(frame_good),
    .frame_bad(frame_bad), .loss(loss), .locked(locked)
  );

  assign flush = !pd_n || loss || frame_bad;

  // two-deep word stage: the word leaves at the frame start two frames on
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a <= '0;
      stage_b <= '0;
      va      <= 1'b0;
      vb      <= 1'b0;
    end else if (flush) begin
      va <= 1'b0;
      vb <= 1'b0;
    end else if (frame_good) begin
      stage_a <= word_now;
      stage_b <= stage_a;
      va      <= 1'b1;
      vb      <= va;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out   <= '0;
      strobe_out <= 1'b0;
    end else begin
      if (!pd_n)                   word_out <= '0;
      else if (start && locked && vb) word_out <= stage_b;
      strobe_out <= pd_n && locked && !loss
                    && in_strobe_window(int'(pos_now), SLOT_BITS);
    end
  end

  // R6
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (word_out == '0 && !strobe_out && !locked));

  // R4
  strobe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !strobe_out);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !(start && locked)) |=> $stable(word_out));

endmodule

// File: tb/septet_lane_rx_test.sv
module septet_lane_rx_test;
  logic clk = 1'b0;
  logic rst_n, pd_n, fc;
  logic [3:0] din;
  logic [27:0] w4;
  logic [20:0] w3;
  logic s4, l4, s3, l3;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [15:0] lhist = '0, shist = '0;

  typedef struct { int due; logic [27:0] w; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  septet_lane_rx #(.LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fc_in(fc), .din(din),
    .word_out(w4), .strobe_out(s4), .locked(l4));

  septet_lane_rx #(.LANES(3)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fc_in(fc), .din(din[2:0]),
    .word_out(w3), .strobe_out(s3), .locked(l3));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lhist <= {lhist[14:0], l4};
    shist <= {shist[14:0], s4};
    if (q.size() > 0) begin
      if (q[0].due == cyc + 1)
        chk({q[0].tag, " R3 early"}, 64'(w4 != q[0].w), 64'd1);
      else if (q[0].due == cyc) begin
        chk({q[0].tag, " R2 R3 word"}, 64'(w4), 64'(q[0].w));
        chk({q[0].tag, " R9 narrow"}, 64'(w3), 64'(q[0].w[20:0]));
        void'(q.pop_front());
      end else if (q[0].due < cyc) begin
        chk({q[0].tag, " R3 missed"}, 64'(cyc), 64'(q[0].due));
        void'(q.pop_front());
      end
    end
  end

  task automatic send_frame(input logic [27:0] w, input bit good, input bit expect_out,
                            input logic pdv, input string tag);
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j == 0 && expect_out) q.push_back('{due: cyc + 15, w: w, tag: tag});
      pd_n = pdv;
      fc = good ? (j < 4) : (j < 2);
      for (int k = 0; k < 4; k++) din[k] = w[7*k + j];
    end
  endtask

  task automatic idle_high(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fc = 1'b1;
      din = '1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pd_n = 1; fc = 0; din = '0;
    repeat (5) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 word", 64'(w4), 64'd0);
    chk("R1 strobe", 64'(s4), 64'd0);
    chk("R1 locked", 64'(l4), 64'd0);
    chk("R1 narrow", 64'({w3, s3, l3}), 64'd0);
    @(negedge clk); rst_n = 1;

    send_frame(28'h0000001, 1, 1, 1, "F0");
    send_frame(28'h8000000, 1, 1, 1, "F1");
    send_frame(28'hFFFFFFF, 1, 1, 1, "F2 R7");
    #1;
    // R5: locked rises right after position 6 of the second good frame
    chk("R5 lock edge", 64'(lhist[7:6]), 64'b01);
    send_frame(28'h0F0F0F0, 1, 1, 1, "F3");
    send_frame(28'h1234567, 1, 0, 1, "F4");
    #1;
    // R4: positions 6(prev),0..5 -> strobe 1,0,0,0,1,1,1
    chk("R4 strobe phase", 64'(shist[6:0]), 64'b1000111);

    idle_high(20);
    #1;
    // R8 loss after 14 quiet bit-times, word holds
    chk("R8 lock at 13", 64'(lhist[5]), 64'd1);
    chk("R8 lock at 14", 64'(lhist[4]), 64'd0);
    chk("R8 strobe low", 64'({s4, s3}), 64'd0);
    chk("R8 hold word", 64'(w4), 64'h0F0F0F0);

    @(negedge clk); fc = 1'b0;
    send_frame(28'h2468ACE, 1, 1, 1, "G0");
    send_frame(28'h7654321, 1, 1, 1, "G1");
    #1;
    chk("R5 one frame no lock", 64'(lhist[6]), 64'd0);
    chk("R8 hold during relock", 64'(w4), 64'h0F0F0F0);
    send_frame(28'h0000080, 1, 1, 1, "G2");
    #1;
    chk("R5 relock", 64'(lhist[6]), 64'd1);
    send_frame(28'h3C3C3C3, 1, 0, 1, "G3");
    send_frame(28'h6969696, 1, 0, 1, "G4");

    send_frame(28'h5555555, 1, 0, 0, "P0");
    #1;
    // R6 power-down forces outputs low
    chk("R6 word", 64'(w4), 64'd0);
    chk("R6 strobe lock", 64'({s4, l4}), 64'd0);
    send_frame(28'hFFFFFFF, 1, 0, 0, "P1");
    #1;
    chk("R6 stays low", 64'({w4, s4, l4}), 64'd0);

    send_frame(28'h1111111, 1, 0, 1, "H0");
    send_frame(28'h2222222, 0, 0, 1, "H1");
    send_frame(28'h4C4C4C4, 1, 1, 1, "H2");
    send_frame(28'h0ABCDEF, 1, 1, 1, "H3");
    #1;
    // R5 a malformed frame breaks the pair
    chk("R5 malformed restarts", 64'(lhist[6]), 64'd0);
    chk("R5 no early word", 64'(w4), 64'd0);
    send_frame(28'h1357913, 1, 0, 1, "H4");
    send_frame(28'h2468024, 1, 0, 1, "H5");
    send_frame(28'h0000000, 1, 0, 1, "H6");
    repeat (4) @(negedge clk);
    #1;
    chk("R3 queue drained", 64'(q.size()), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule